// File: doc/BRIEF.md
# Descriptor Ring Producer with Lap Stamping

This block fills a circular ring of fixed-size descriptors kept in a local memory. Each ring slot holds eight 32-bit words. An upstream agent hands over a descriptor one word per valid/ready handshake, and the block stores the words in order into the slot at the head pointer. When it stores the eighth word of a slot, it replaces two fields of that word. One field gets a programmable 8-bit ring identifier. The other gets a 4-bit lap number.

The lap number is 1 for every slot written on the first pass through the ring. It goes up by one each time the head pointer wraps, and it rolls over from 15 to 0. A downstream reader that knows which pass it expects can therefore tell a fresh slot from a stale one by testing only the least significant bit of the lap field. It does not have to poll the head pointer.

The reader reports its progress by writing a tail index. It fetches slot contents through an asynchronous read port. The block shows the head index and a full flag, and it raises a one-cycle pulse each time a slot is completed.

Top module: `desc_ring_producer`

## Requirements
- R1: Accepted words are stored in acceptance order at word address head*8 + k, where k counts 0..7 within the slot. The read port returns the stored word of address rd_addr_i in the same cycle.
- R2: In the eighth word (k = 7) of each slot, bits [27:20] are replaced by the value of ring_id_i at the cycle that word is accepted.
- R3: In the eighth word of each slot, bits [31:28] are replaced by the lap number. Slots written before the first head wrap carry lap 1.
- R4: The lap register is 0 after reset and increments, modulo 16, exactly when the head wraps from DEPTH-1 to 0. A slot carries (lap register + 1) mod 16, so the seventeenth pass writes 1 again after the sixteenth pass wrote 0.
- R5: head_o advances by one, modulo DEPTH, only in the cycle after the eighth word of a slot is accepted. It is otherwise unchanged.
- R6: full_o is 1 exactly when (head_o + 1) mod DEPTH equals the stored tail. While full_o is 1, in_ready_o is 0 and no memory word changes, including when a slot is only partly written.
- R7: irq_o is 1 for exactly one cycle, the cycle after each eighth word is accepted.
- R8: After reset every memory word reads 0, head_o is 0, the tail is 0, full_o and irq_o are 0, and in_ready_o is 1.
- R9: Words 0..6 of a slot are stored unchanged, and bits [19:0] of word 7 are stored unchanged.
- R10: A tail write takes effect on the next clock edge, and full_o reflects the new tail in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_id_i | input | 8 | Identifier stamped into bits [27:20] of each slot's last word |
| in_valid_i | input | 1 | Producer word valid |
| in_word_i | input | 32 | Producer data word |
| in_ready_o | output | 1 | Block can accept a word (not full) |
| tail_we_i | input | 1 | Tail index write strobe |
| tail_i | input | PTR_W (3) | New tail slot index |
| rd_addr_i | input | PTR_W+3 (6) | Word address for the read port |
| rd_data_o | output | 32 | Memory word at rd_addr_i |
| head_o | output | PTR_W (3) | Slot index of the next slot to fill |
| full_o | output | 1 | Ring full |
| irq_o | output | 1 | One-cycle pulse per completed slot |

## Verification
Some properties are checked by assertions on every cycle:
- the head stays put unless a slot completes;
- while the ring is full and the tail is not rewritten, neither the head nor the word position moves;
- the lap register changes only in the cycle where the head has just returned to 0;
- the completion pulse never lasts two cycles.

The bench scenarios cover what the assertions cannot see. They confirm the stored contents through the read port: the stamped identifier and lap fields, the lap rollover from 15 to 0 and back to 1, untouched payload bits, and memory left unchanged while full. They also check the full flag raised partway through a slot and released again by a tail update.

// File: rtl/ring_pkg.sv
package ring_pkg;
    localparam int WORD_W       = 32;
    localparam int SLOT_WORDS   = 8;
    localparam int ID_W         = 8;
    localparam int LAP_W        = 4;
    // stamp field positions inside the last word of a slot; consumers decode these
    localparam int ID_LSB       = 20;
    localparam int LAP_LSB      = ID_LSB + ID_W;
    localparam int KEEP_W       = ID_LSB;

    function automatic logic [WORD_W-1:0] apply_stamp(
        input logic [WORD_W-1:0] raw,
        input logic [ID_W-1:0]   id,
        input logic [LAP_W-1:0]  lap
    );
        return {lap, id, raw[KEEP_W-1:0]};
    endfunction
endpackage

// File: rtl/ring_ptr_ctrl.sv
module ring_ptr_ctrl #(
    parameter int DEPTH = 8,
    parameter int WORDS = ring_pkg::SLOT_WORDS,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid_i,
    input  logic                     tail_we_i,
    input  logic [PTR_W-1:0]         tail_i,
    output logic                     in_ready_o,
    output logic                     wr_en_o,
    output logic                     wr_last_o,
    output logic [PTR_W+IDX_W-1:0]   wr_addr_o,
    output logic [ring_pkg::LAP_W-1:0] stamp_lap_o,
    output logic [PTR_W-1:0]         head_o,
    output logic                     full_o,
    output logic                     irq_o
);
    import ring_pkg::*;

    typedef struct packed {
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] tail;
        logic [IDX_W-1:0] widx;
        logic [LAP_W-1:0] lap;
        logic             irq;
    } ctrl_state_t;

    ctrl_state_t st_q, st_d;
    logic full, acc, last;

    always_comb begin
        st_d = st_q;
        full = (PTR_W'(st_q.head + 1'b1) == st_q.tail);
        acc  = in_valid_i && !full;
        last = (st_q.widx == IDX_W'(WORDS - 1));
        st_d.irq = 1'b0;
        if (acc) begin
            if (last) begin
                st_d.widx = '0;
                st_d.head = PTR_W'(st_q.head + 1'b1);
                st_d.irq  = 1'b1;
                if (st_q.head == PTR_W'(DEPTH - 1)) begin
                    st_d.lap = LAP_W'(st_q.lap + 1'b1);
                end
            end else begin
                st_d.widx = IDX_W'(st_q.widx + 1'b1);
            end
        end
        if (tail_we_i) begin
            st_d.tail = tail_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready_o  = !full;
    assign wr_en_o     = acc;
    assign wr_last_o   = last;
    assign wr_addr_o   = {st_q.head, st_q.widx};
    assign stamp_lap_o = LAP_W'(st_q.lap + 1'b1);
    assign head_o      = st_q.head;
    assign full_o      = full;
    assign irq_o       = st_q.irq;

    // R5: head only moves on slot completion
    a_r5_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc && last) |=> $stable(st_q.head));

    // R6: a full ring with no tail update freezes the fill position
    a_r6_full_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !tail_we_i) |=> ($stable(st_q.head) && $stable(st_q.widx)));

    // R4: lap changes only together with a head wrap to zero
    a_r4_lap_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lap != $past(st_q.lap)) |-> (st_q.head == '0));

    // R7: completion pulse lasts one cycle
    a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |=> !st_q.irq);
endmodule

// File: rtl/ring_lap_stamper.sv
module ring_lap_stamper (
    input  logic [ring_pkg::WORD_W-1:0] word_i,
    input  logic                        last_i,
    input  logic [ring_pkg::ID_W-1:0]   id_i,
    input  logic [ring_pkg::LAP_W-1:0]  lap_i,
    output logic [ring_pkg::WORD_W-1:0] word_o
);
    import ring_pkg::*;

    always_comb begin
        word_o = word_i;
        if (last_i) begin
            word_o = apply_stamp(word_i, id_i, lap_i);
        end
    end
endmodule

// File: rtl/ring_store.sv
module ring_store #(
    parameter int ADDR_W = 6,
    localparam int N     = 1 << ADDR_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we_i,
    input  logic [ADDR_W-1:0]           waddr_i,
    input  logic [ring_pkg::WORD_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0]           raddr_i,
    output logic [ring_pkg::WORD_W-1:0] rdata_o
);
    import ring_pkg::*;

    logic [WORD_W-1:0] mem_q [N];
    logic [WORD_W-1:0] mem_d [N];

    always_comb begin
        for (int i = 0; i < N; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we_i) begin
            mem_d[waddr_i] = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/desc_ring_producer.sv
module desc_ring_producer #(
    parameter int DEPTH = 8,
    localparam int WORDS  = ring_pkg::SLOT_WORDS,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int IDX_W  = $clog2(WORDS),
    localparam int ADDR_W = PTR_W + IDX_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ring_pkg::ID_W-1:0]   ring_id_i,
    input  logic                        in_valid_i,
    input  logic [ring_pkg::WORD_W-1:0] in_word_i,
    output logic                        in_ready_o,
    input  logic                        tail_we_i,
    input  logic [PTR_W-1:0]            tail_i,
    input  logic [ADDR_W-1:0]           rd_addr_i,
    output logic [ring_pkg::WORD_W-1:0] rd_data_o,
    output logic [PTR_W-1:0]            head_o,
    output logic                        full_o,
    output logic                        irq_o
);
    import ring_pkg::*;

    logic              wr_en, wr_last;
    logic [ADDR_W-1:0] wr_addr;
    logic [LAP_W-1:0]  stamp_lap;
    logic [WORD_W-1:0] wr_data;

    ring_ptr_ctrl #(.DEPTH(DEPTH), .WORDS(WORDS)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid_i (in_valid_i),
        .tail_we_i  (tail_we_i),
        .tail_i     (tail_i),
        .in_ready_o (in_ready_o),
        .wr_en_o    (wr_en),
        .wr_last_o  (wr_last),
        .wr_addr_o  (wr_addr),
        .stamp_lap_o(stamp_lap),
        .head_o     (head_o),
        .full_o     (full_o),
        .irq_o      (irq_o)
    );

    ring_lap_stamper stamp_i (
        .word_i (in_word_i),
        .last_i (wr_last),
        .id_i   (ring_id_i),
        .lap_i  (stamp_lap),
        .word_o (wr_data)
    );

    ring_store #(.ADDR_W(ADDR_W)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wr_en),
        .waddr_i (wr_addr),
        .wdata_i (wr_data),
        .raddr_i (rd_addr_i),
        .rdata_o (rd_data_o)
    );
endmodule

// File: tb/desc_ring_producer_tb_top.sv
module desc_ring_producer_tb_top;
    localparam int D     = 8;
    localparam int W     = 8;
    localparam int PW    = $clog2(D);
    localparam int AW    = PW + 3;
    localparam int NW    = D * W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0]  ring_id = 8'h00;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        in_ready;
    logic        tail_we = 1'b0;
    logic [PW-1:0] tail_v = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic [PW-1:0] head;
    logic        full, irq;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int wcount   = 0;

    // reference model state
    logic [31:0] m_mem [NW];
    int m_head = 0, m_tail = 0, m_widx = 0, m_lap = 0;
    bit m_irq = 0;

    always #10 clk = ~clk;

    desc_ring_producer #(.DEPTH(D)) dut_i (
        .clk(clk), .rst_n(rst_n), .ring_id_i(ring_id), .in_valid_i(in_valid),
        .in_word_i(in_word), .in_ready_o(in_ready), .tail_we_i(tail_we),
        .tail_i(tail_v), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .head_o(head), .full_o(full), .irq_o(irq)
    );

    function automatic bit m_full();
        return ((m_head + 1) % D) == m_tail;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NW; i++) m_mem[i] = '0;
            m_head = 0; m_tail = 0; m_widx = 0; m_lap = 0; m_irq = 0;
        end else begin
            m_irq = 0;
            if (in_valid && !m_full()) begin
                logic [31:0] w;
                logic [3:0] lp;
                w = in_word;
                lp = 4'((m_lap + 1) % 16);
                if (m_widx == W - 1) w = {lp, ring_id, in_word[19:0]};
                m_mem[m_head * W + m_widx] = w;
                m_widx++;
                if (m_widx == W) begin
                    m_widx = 0;
                    m_irq  = 1;
                    m_head = (m_head + 1) % D;
                    if (m_head == 0) m_lap = (m_lap + 1) % 16;
                end
            end
            if (tail_we) m_tail = int'(tail_v);
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // per-cycle comparison of the control outputs against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R5 head", 32'(head), 32'(m_head));
            chk("R6 R10 full", 32'(full), 32'(m_full()));
            chk("R6 ready", 32'(in_ready), 32'(!m_full()));
            chk("R7 irq", 32'(irq), 32'(m_irq));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    // full memory readback through the read port
    task automatic sweep(input string req);
        for (int a = 0; a < NW; a++) begin
            @(negedge clk);
            rd_addr = AW'(a);
            #2;
            chk(req, rd_data, m_mem[a]);
        end
    endtask

    task automatic send_word(input bit gap);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = 32'hC3A5_0000 ^ (32'(wcount) * 32'h0101_0107);
        wcount++;
        forever begin
            bit rdy;
            rdy = in_ready;
            @(negedge clk);
            if (rdy) break;
        end
        in_valid = 1'b0;
        if (gap) @(negedge clk);
    endtask

    task automatic send_slot(input bit gappy);
        for (int k = 0; k < W; k++) send_word(gappy && (k % 3 == 1));
    endtask

    task automatic set_tail(input int v);
        @(negedge clk);
        tail_we = 1'b1;
        tail_v  = PW'(v);
        @(negedge clk);
        tail_we = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        chk("R8 head", 32'(head), 32'd0);
        chk("R8 full", 32'(full), 32'd0);
        chk("R8 irq", 32'(irq), 32'd0);
        chk("R8 ready", 32'(in_ready), 32'd1);
        sweep("R8 memory clear");

        // R1 R2 R9: fill until full, varying id and gaps
        for (int e = 0; e < D - 1; e++) begin
            ring_id = 8'(8'h30 + e * 17);
            send_slot(e[0]);
        end
        sweep("R1 R2 R3 R9 first pass");

        // R6: held valid while full must not write
        chk("R6 full after fill", 32'(full), 32'd1);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = 32'hDEAD_BEEF;
        repeat (5) @(negedge clk);
        in_valid = 1'b0;
        sweep("R6 no overwrite when full");

        // R10 R4: free space, complete the slot that wraps the head
        set_tail(3);
        ring_id = 8'hE1;
        send_slot(1'b0);
        chk("R4 head wrapped", 32'(head), 32'd0);

        // R6: ring becomes full partway through a slot
        for (int k = 0; k < 4; k++) send_word(1'b0);
        set_tail(1);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = 32'h5555_AAAA;
        repeat (4) @(negedge clk);
        in_valid = 1'b0;
        sweep("R6 partial slot frozen");
        set_tail(3);
        for (int k = 4; k < W; k++) send_word(1'b0);
        sweep("R3 R4 second pass");

        // R4: many laps including the 15 to 0 rollover
        for (int e = 0; e < 130; e++) begin
            ring_id = 8'(e * 7 + 1);
            send_slot(e % 5 == 0);
            set_tail((m_head + 5) % D);
            if (e == 100) sweep("R1 R2 R3 R4 R9 mid run");
        end
        sweep("R2 R3 R4 R9 after rollover");

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule